// File: doc/BRIEF.md
# Lockable Watchdog and Interval Timer

This block is a supervision timer with three overflow actions. A free-running prescaler divides the input clock. A clock-select input picks one of its taps as the tick for an up-counter. When that counter wraps, the block raises a maskable interrupt request, a non-maskable interrupt request, or a system reset request. An 8-bit control register on a simple write bus picks the action.

The control register can only move towards more protection. Software can set the start bit and the two action bits, but it cannot clear them; only the synchronous hardware reset does. A write that sets the start bit clears the counter and starts it again. The prescaler keeps running through that write, so the first wrap after a restart can come up to one prescaler tap period early. In the two interrupt actions, each wrap also pulses an output that can shut down an external PWM stage.

Top module: `wdt_lock_timer`

## Requirements
- R1: After reset, `rd_data` is 0x00 and `irq_int`, `irq_nmi`, `rst_req` and `pwm_off` are all low.
- R2: `rd_data` shows the start bit at bit 7, the upper action bit at bit 4 and the lower action bit at bit 3. All other bits read 0, even after a write of 0xFF, which reads back as 0x98.
- R3: Once the start bit is set, a write with bit 7 at 0 neither clears it nor stops the counter.
- R4: Once an action bit is set, a write with that bit at 0 does not clear it.
- R5: A write with `wr_addr` different from `REG_ADDR` changes nothing and does not start the counter.
- R6: With bit 4 at 0 (bit 3 ignored), each wrap gives a one-cycle `irq_int` pulse. Consecutive pulses are exactly 2^(`clk_sel`+`PRE_BASE`) × 2^`CNT_W` clocks apart.
- R7: With bit 4 at 1 and bit 3 at 0, each wrap gives a one-cycle `irq_nmi` pulse.
- R8: With bits 4 and 3 both at 1, each wrap gives a one-cycle `rst_req` pulse, and `pwm_off` stays low.
- R9: In the two interrupt actions, `pwm_off` pulses in the same cycle as the interrupt request.
- R10: A write that sets bit 7 clears the counter but not the prescaler. Let T = 2^(`clk_sel`+`PRE_BASE`) and N = 2^`CNT_W`. The first wrap pulse then appears L clock edges after the write edge, with (N-1)·T < L ≤ N·T.
- R11: While the start bit is 0, no request or `pwm_off` pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| clk_sel | input | SEL_W | Prescaler tap select |
| rd_data | output | 8 | Control register readback |
| irq_int | output | 1 | Maskable interrupt request pulse |
| irq_nmi | output | 1 | Non-maskable interrupt request pulse |
| rst_req | output | 1 | System reset request pulse |
| pwm_off | output | 1 | PWM shutdown pulse |

## Verification
The bench builds the block with `PRE_BASE` = 2 and `CNT_W` = 3. With these values a tap period is 4 to 16 clocks and a full wrap takes 32 to 128 clocks. Each action can therefore wrap several times within a short run. At these sizes the exact spacing between pulses and the shortened first wrap after a restart can both be measured cycle by cycle, for several `clk_sel` values. The bench also checks that the start and action bits stay set against writes that try to clear them.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_RUN = 7;
  localparam int BIT_MHI = 4;
  localparam int BIT_MLO = 3;

  typedef enum logic [1:0] {
    ACT_INT = 2'd0,
    ACT_NMI = 2'd1,
    ACT_RST = 2'd2
  } act_e;

  function automatic act_e act_of(input logic m_hi, input logic m_lo);
    if (!m_hi)     return ACT_INT;
    else if (!m_lo) return ACT_NMI;
    else           return ACT_RST;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_BASE = 8,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             tick
);
  localparam int TAPS  = 1 << SEL_W;
  localparam int PRE_W = PRE_BASE + TAPS - 1;

  logic [PRE_W-1:0] pre_q;
  logic [TAPS-1:0]  tap_hit;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // tap k fires once every 2^(k+PRE_BASE) clocks
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tap_hit[k] = &pre_q[k+PRE_BASE-1:0];
  end

  assign tick = tap_hit[clk_sel];
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg #(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [wdt_pkg::REG_W-1:0] wr_data,
  output logic                      run,
  output logic                      m_hi,
  output logic                      m_lo,
  output logic                      restart,
  output logic [wdt_pkg::REG_W-1:0] rd_data
);
  import wdt_pkg::*;

  logic hit;
  assign hit     = wr_en && (wr_addr == REG_ADDR);
  assign restart = hit && wr_data[BIT_RUN];

  // set-only bits: a write can raise them, only reset lowers them
  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      m_hi <= 1'b0;
      m_lo <= 1'b0;
    end else if (hit) begin
      run  <= run  | wr_data[BIT_RUN];
      m_hi <= m_hi | wr_data[BIT_MHI];
      m_lo <= m_lo | wr_data[BIT_MLO];
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_RUN] = run;
    rd_data[BIT_MHI] = m_hi;
    rd_data[BIT_MLO] = m_lo;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic          tick,
  input  wdt_pkg::act_e act,
  output logic          irq_int,
  output logic          irq_nmi,
  output logic          rst_req,
  output logic          pwm_off
);
  import wdt_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = run && tick && !restart && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || restart)    cnt_q <= '0;
    else if (run && tick)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_int <= 1'b0;
      irq_nmi <= 1'b0;
      rst_req <= 1'b0;
      pwm_off <= 1'b0;
    end else begin
      irq_int <= wrap && (act == ACT_INT);
      irq_nmi <= wrap && (act == ACT_NMI);
      rst_req <= wrap && (act == ACT_RST);
      pwm_off <= wrap && (act != ACT_RST);
    end
  end
endmodule

// File: rtl/wdt_lock_timer.sv
module wdt_lock_timer #(
  parameter int                PRE_BASE = 8,
  parameter int                SEL_W    = 3,
  parameter int                CNT_W    = 8,
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [wdt_pkg::REG_W-1:0] wr_data,
  input  logic [SEL_W-1:0]          clk_sel,
  output logic [wdt_pkg::REG_W-1:0] rd_data,
  output logic                      irq_int,
  output logic                      irq_nmi,
  output logic                      rst_req,
  output logic                      pwm_off
);
  import wdt_pkg::*;

  logic run, m_hi, m_lo, restart, tick;
  act_e act;

  assign act = act_of(m_hi, m_lo);

  wdt_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .m_hi(m_hi), .m_lo(m_lo), .restart(restart), .rd_data(rd_data)
  );

  wdt_prescaler #(.PRE_BASE(PRE_BASE), .SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .tick(tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .restart(restart), .tick(tick), .act(act),
    .irq_int(irq_int), .irq_nmi(irq_nmi), .rst_req(rst_req), .pwm_off(pwm_off)
  );
endmodule

// File: rtl/wdt_lock_timer_chk.sv
module wdt_lock_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] rd_data,
  input logic       irq_int,
  input logic       irq_nmi,
  input logic       rst_req,
  input logic       pwm_off
);
  p_run_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    rd_data[7] |=> rd_data[7]);
  p_hi_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    rd_data[4] |=> rd_data[4]);
  p_lo_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    rd_data[3] |=> rd_data[3]);
  p_one_action_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_int, irq_nmi, rst_req}));
  p_int_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    irq_int |=> !irq_int);
  p_nmi_mode_r7: assert property (@(posedge clk) disable iff (rst)
    irq_nmi |-> (rd_data[4] && rd_data[7]));
  p_rst_no_pwm_r8: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (!pwm_off && rd_data[4] && rd_data[3]));
  p_pwm_pair_r9: assert property (@(posedge clk) disable iff (rst)
    pwm_off |-> (irq_int || irq_nmi));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_data[7] |-> !(irq_int || irq_nmi || rst_req || pwm_off));
endmodule

bind wdt_lock_timer wdt_lock_timer_chk u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .irq_int(irq_int),
  .irq_nmi(irq_nmi), .rst_req(rst_req), .pwm_off(pwm_off)
);

// File: tb/wdt_lock_timer_test.sv
`timescale 1ns/1ps
module wdt_lock_timer_test;
  localparam int PB = 2;
  localparam int SW = 3;
  localparam int CW = 3;
  localparam int AW = 4;
  localparam logic [AW-1:0] RA = 4'h9;
  localparam int N = 1 << CW;

  typedef struct packed {
    logic [2:0] sel;
    logic [1:0] mode;   // {bit4, bit3}
    logic [1:0] kind;   // 0 int, 1 nmi, 2 rst
  } vec_t;
  localparam vec_t VECS [5] = '{
    '{3'd0, 2'b00, 2'd0},
    '{3'd1, 2'b01, 2'd0},
    '{3'd0, 2'b10, 2'd1},
    '{3'd2, 2'b11, 2'd2},
    '{3'd1, 2'b10, 2'd1}
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [SW-1:0] clk_sel = '0;
  logic [7:0] rd_data;
  logic irq_int, irq_nmi, rst_req, pwm_off;
  int errors = 0, checks = 0, cyc = 0;

  always #2.5 clk = ~clk;

  wdt_lock_timer #(.PRE_BASE(PB), .SEL_W(SW), .CNT_W(CW), .ADDR_W(AW), .REG_ADDR(RA)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_sel(clk_sel), .rd_data(rd_data), .irq_int(irq_int), .irq_nmi(irq_nmi),
    .rst_req(rst_req), .pwm_off(pwm_off)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, got %0d cycles, expected fewer", cyc);
      report();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic any_req();
    return irq_int | irq_nmi | rst_req;
  endfunction

  // edges counted from the last write edge until a request is seen
  task automatic wait_req(output int n);
    n = 0;
    while (!any_req() && n < 4000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int n, m, t;
    logic [2:0] seen;
    logic pw;
    do_reset();
    @(negedge clk);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 outputs", {irq_int, irq_nmi, rst_req, pwm_off}, 0);

    // table walk: each action, tap and first-wrap bound
    foreach (VECS[i]) begin
      do_reset();
      clk_sel = VECS[i].sel;
      t = 1 << (VECS[i].sel + PB);
      wr(RA, {3'b000, VECS[i].mode, 3'b000});
      repeat (7) @(negedge clk);
      wr(RA, 8'h80);
      wait_req(n);
      chk_range("R10 first wrap latency", n, (N-1)*t + 1, N*t);
      seen = {rst_req, irq_nmi, irq_int};
      pw = pwm_off;
      chk("R6/R7/R8 action kind", seen, 3'b001 << VECS[i].kind);
      chk("R9/R8 pwm_off", pw, VECS[i].kind != 2);
      @(negedge clk); m = 1;
      chk("R6 single-cycle pulse", any_req(), 0);
      while (!any_req() && m < 4000) begin @(negedge clk); m++; end
      chk("R6 wrap spacing", m, N*t);
    end

    // R2: unused bits read zero
    do_reset();
    wr(RA, 8'hFF);
    chk("R2 readback of 0xFF", rd_data, 8'h98);

    // R5: other address ignored
    do_reset();
    wr(4'h3, 8'h98);
    chk("R5 rd_data unchanged", rd_data, 0);
    n = 0;
    repeat (200) begin @(negedge clk); if (any_req() || pwm_off) n++; end
    chk("R5/R11 no pulse without start", n, 0);

    // R3 / R4: clearing writes have no effect
    do_reset();
    clk_sel = 0;
    wr(RA, 8'h90);
    wr(RA, 8'h00);
    chk("R3 run bit kept", rd_data[7], 1);
    chk("R4 upper action bit kept", rd_data[4], 1);
    wait_req(n);
    chk_range("R3 counter still running", n, 1, N*4);
    chk("R4/R7 nmi after clear attempt", irq_nmi, 1);

    // R10: restart mid-count delays the wrap
    do_reset();
    clk_sel = 1; t = 8;
    wr(RA, 8'h80);
    repeat (40) @(negedge clk);
    wr(RA, 8'h80);
    wait_req(n);
    chk_range("R10 restart latency", n, (N-1)*t + 1, N*t);
    chk("R6 interval after restart", irq_int, 1);

    report();
  end
endmodule